// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface and walks the memory through its required power-up initialization after reset. Once the supply-stable flag rises, it keeps the clock enable low for a counted settling window. It then raises the clock enable and issues a fixed script of precharge, refresh and mode-register writes. The register write commands take their operating bits from two configuration inputs. When the script is finished and the DLL has had its lock window, a done flag rises and stays high.

All waits are cycle-count parameters, worked out from the clock period by whoever instantiates the block. Examples are the 200 µs settle time, the 400 ns pause after the clock enable rises, tMRD, tRP, tRFC and the 200-cycle DLL lock. The command pins are registered. Each command is a single-cycle pulse. Every cycle between commands is a NOP. On-die termination is held off for the whole sequence. A synchronous reset starts everything again from the clock-enable-low wait.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is high, and on the first sampled cycle after reset is asserted (even mid-sequence), the outputs are: cke=0, csN=1 (deselect), rasN=casN=weN=1, ba=0, addr=0, initDone=0, odt=0.
- R2: After reset, cke rises after exactly CKE_WAIT clock cycles in which pwrStable was sampled high. Once high, cke stays high until the next reset.
- R3: The first command is PRECHARGE ALL, with addr bit 10 = 1, ba=0 and all other address bits 0. It appears exactly POST_CKE cycles after cke rises.
- R4: Commands use csN=0 together with {rasN,casN,weN}: PRECHARGE=010, REFRESH=001, LOAD MODE=000, NOP=111. A command lasts one cycle, every other cycle after reset is a NOP, and exactly 11 commands are issued.
- R5: Commands 2 to 4 are LOAD MODE writes in this order. First ba=2 with addr=0. Then ba=3 with addr=0. Then ba=1 with addr = extModeCfg with bit 0 cleared (DLL enabled) and bits 9:7 cleared.
- R6: Command 5 is LOAD MODE with ba=0 and addr = modeCfg with bit 8 forced to 1 (DLL reset). It starts a DLL_LOCK-cycle lock count.
- R7: Command 6 is PRECHARGE ALL (as in R3). It is followed by NUM_REF (default 2) REFRESH commands with ba=0 and addr=0.
- R8: Next comes LOAD MODE with ba=0 and addr = modeCfg with bit 8 forced to 0.
- R9: The last two commands are LOAD MODE with ba=1. The first has addr bits 9:7 = 111 and the second has bits 9:7 = 000. Both take their other bits from extModeCfg, with bit 0 cleared.
- R10: The gap from a command to the next one is exactly T_MRD cycles after LOAD MODE, T_RP after PRECHARGE and T_RFC after REFRESH.
- R11: initDone rises in the later of two cycles: DLL_LOCK cycles after the DLL-reset write, or T_MRD cycles after the final write. It then stays high with cke high and only NOPs until reset.
- R12: odt is 0 in every cycle.
- R13: While pwrStable stays low after reset, cke stays 0, only NOPs are issued and initDone stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| pwrStable | input | 1 | Supplies and memory clock are stable |
| modeCfg | input | ADDR_W | Desired main mode register bits |
| extModeCfg | input | ADDR_W | Desired extended mode register bits |
| cke | output | 1 | Memory clock enable |
| odt | output | 1 | On-die termination control, held low |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address / mode register select |
| addr | output | ADDR_W | Address bus / mode register contents |
| initDone | output | 1 | Initialization complete, sticky until reset |

## Verification
A sequencer state that is off by one step shows up at once as a command with the wrong bank select or address bits, or in the wrong order. A miscounting wait counter shifts every later command by a fixed number of cycles, so the bench compares each command's cycle against a chain of expected cycles built from the parameters, not against a lower bound. If the DLL counter is broken, initDone appears too early or too late. The bench therefore checks the exact cycle of initDone against the later of its two deadlines, and also checks that it does not drop afterwards.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    CMD_NONE,
    CMD_PREA,
    CMD_REF,
    CMD_EMR2,
    CMD_EMR3,
    CMD_EMR_DLL,
    CMD_MR_DLLRST,
    CMD_MR_OP,
    CMD_EMR_OCD,
    CMD_EMR_EXIT
  } cmdSel_e;

  typedef struct packed {
    cmdSel_e cmd;
    logic    loadCkeWait;
    logic    loadPostWait;
    logic    ckeOn;
  } seqStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CKE_LOW,
    ST_PRE_A,
    ST_EMR2,
    ST_EMR3,
    ST_EMR_DLL,
    ST_MR_RST,
    ST_PRE_B,
    ST_REF,
    ST_MR_OP,
    ST_EMR_OCD,
    ST_EMR_EXIT,
    ST_DLL_WAIT,
    ST_DONE
  } seqState_e;

endpackage

// File: rtl/ddr2_init_ctrl.sv
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int NUM_REF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwrStable,
  input  logic       waitZero,
  input  logic       dllDone,
  output seqStrobe_t strobe,
  output logic       initDone
);

  localparam int REF_W = $clog2(NUM_REF + 1);

  seqState_e        state, stateNext;
  logic [REF_W-1:0] refCnt;

  always_comb begin
    strobe     = '0;
    strobe.cmd = CMD_NONE;
    stateNext  = state;
    case (state)
      ST_IDLE: if (pwrStable) begin
        strobe.loadCkeWait = 1'b1;
        stateNext          = ST_CKE_LOW;
      end
      ST_CKE_LOW: if (waitZero) begin
        strobe.ckeOn        = 1'b1;
        strobe.loadPostWait = 1'b1;
        stateNext           = ST_PRE_A;
      end
      ST_PRE_A: if (waitZero) begin
        strobe.cmd = CMD_PREA;
        stateNext  = ST_EMR2;
      end
      ST_EMR2: if (waitZero) begin
        strobe.cmd = CMD_EMR2;
        stateNext  = ST_EMR3;
      end
      ST_EMR3: if (waitZero) begin
        strobe.cmd = CMD_EMR3;
        stateNext  = ST_EMR_DLL;
      end
      ST_EMR_DLL: if (waitZero) begin
        strobe.cmd = CMD_EMR_DLL;
        stateNext  = ST_MR_RST;
      end
      ST_MR_RST: if (waitZero) begin
        strobe.cmd = CMD_MR_DLLRST;
        stateNext  = ST_PRE_B;
      end
      ST_PRE_B: if (waitZero) begin
        strobe.cmd = CMD_PREA;
        stateNext  = ST_REF;
      end
      ST_REF: if (waitZero) begin
        strobe.cmd = CMD_REF;
        if (refCnt == REF_W'(NUM_REF - 1)) stateNext = ST_MR_OP;
      end
      ST_MR_OP: if (waitZero) begin
        strobe.cmd = CMD_MR_OP;
        stateNext  = ST_EMR_OCD;
      end
      ST_EMR_OCD: if (waitZero) begin
        strobe.cmd = CMD_EMR_OCD;
        stateNext  = ST_EMR_EXIT;
      end
      ST_EMR_EXIT: if (waitZero) begin
        strobe.cmd = CMD_EMR_EXIT;
        stateNext  = ST_DLL_WAIT;
      end
      ST_DLL_WAIT: if (waitZero && dllDone) stateNext = ST_DONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      refCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.cmd == CMD_REF) refCnt <= refCnt + 1'b1;
    end
  end

  assign initDone = (state == ST_DONE);

  // R7: the operating-mode write is reached only after every refresh went out
  assert_ref_count_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MR_OP) |-> (refCnt == REF_W'(NUM_REF)));

endmodule

// File: rtl/ddr2_init_datapath.sv
module ddr2_init_datapath
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BA_W     = 3,
  parameter int CKE_WAIT = 50000,
  parameter int POST_CKE = 100,
  parameter int DLL_LOCK = 200,
  parameter int T_MRD    = 2,
  parameter int T_RP     = 4,
  parameter int T_RFC    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] modeCfg,
  input  logic [ADDR_W-1:0] extModeCfg,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              waitZero,
  output logic              dllDone
);

  localparam int MAX_A    = (CKE_WAIT > POST_CKE) ? CKE_WAIT : POST_CKE;
  localparam int MAX_B    = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int MAX_C    = (MAX_B > T_MRD) ? MAX_B : T_MRD;
  localparam int MAX_WAIT = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);
  localparam int DLL_W    = $clog2(DLL_LOCK + 1);
  localparam int BIT_DLL_OFF  = 0;
  localparam int BIT_DLL_RST  = 8;
  localparam int BIT_ALL_BANK = 10;
  localparam int OCD_LO       = 7;
  localparam int OCD_HI       = 9;

  logic [WAIT_W-1:0] waitCnt;
  logic [DLL_W-1:0]  dllCnt;
  logic              dllRun;

  // next command pin values
  logic [2:0]        rcwNext;
  logic [BA_W-1:0]   baNext;
  logic [ADDR_W-1:0] addrNext, emrBase;
  logic              gapLoad;
  logic [WAIT_W-1:0] gapVal;

  always_comb begin
    emrBase                 = extModeCfg;
    emrBase[BIT_DLL_OFF]    = 1'b0;
    emrBase[OCD_HI:OCD_LO]  = '0;
    rcwNext  = 3'b111;
    baNext   = '0;
    addrNext = '0;
    case (strobe.cmd)
      CMD_PREA: begin
        rcwNext                = 3'b010;
        addrNext[BIT_ALL_BANK] = 1'b1;
      end
      CMD_REF:  rcwNext = 3'b001;
      CMD_EMR2: begin
        rcwNext = 3'b000;
        baNext  = BA_W'(2);
      end
      CMD_EMR3: begin
        rcwNext = 3'b000;
        baNext  = BA_W'(3);
      end
      CMD_EMR_DLL, CMD_EMR_EXIT: begin
        rcwNext  = 3'b000;
        baNext   = BA_W'(1);
        addrNext = emrBase;
      end
      CMD_EMR_OCD: begin
        rcwNext                 = 3'b000;
        baNext                  = BA_W'(1);
        addrNext                = emrBase;
        addrNext[OCD_HI:OCD_LO] = '1;
      end
      CMD_MR_DLLRST: begin
        rcwNext               = 3'b000;
        addrNext              = modeCfg;
        addrNext[BIT_DLL_RST] = 1'b1;
      end
      CMD_MR_OP: begin
        rcwNext               = 3'b000;
        addrNext              = modeCfg;
        addrNext[BIT_DLL_RST] = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    gapLoad = 1'b1;
    gapVal  = '0;
    if (strobe.loadCkeWait)       gapVal = WAIT_W'(CKE_WAIT - 1);
    else if (strobe.loadPostWait) gapVal = WAIT_W'(POST_CKE - 1);
    else begin
      case (strobe.cmd)
        CMD_NONE: gapLoad = 1'b0;
        CMD_PREA: gapVal  = WAIT_W'(T_RP - 1);
        CMD_REF:  gapVal  = WAIT_W'(T_RFC - 1);
        default:  gapVal  = WAIT_W'(T_MRD - 1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke                <= 1'b0;
      csN                <= 1'b1;
      {rasN, casN, weN}  <= 3'b111;
      ba                 <= '0;
      addr               <= '0;
      waitCnt            <= '0;
      dllCnt             <= '0;
      dllRun             <= 1'b0;
    end else begin
      if (strobe.ckeOn) cke <= 1'b1;
      csN               <= 1'b0;
      {rasN, casN, weN} <= rcwNext;
      ba                <= baNext;
      addr              <= addrNext;
      if (gapLoad)             waitCnt <= gapVal;
      else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
      if (strobe.cmd == CMD_MR_DLLRST) begin
        dllCnt <= DLL_W'(DLL_LOCK - 1);
        dllRun <= 1'b1;
      end else if (dllRun && dllCnt != '0) begin
        dllCnt <= dllCnt - 1'b1;
      end
    end
  end

  assign waitZero = (waitCnt == '0);
  assign dllDone  = dllRun && (dllCnt == '0);

  // R2: clock enable never drops once raised
  assert_cke_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  // R4: no real command while the clock enable is still low
  assert_cmd_needs_cke_R4: assert property (@(posedge clk) disable iff (rst)
    !(rasN && casN && weN) |-> cke);

  // R10: spacing between commands seen at the pins, counted by a checker counter
  logic [WAIT_W:0] sinceCmd, needGap;
  always_ff @(posedge clk) begin
    if (rst) begin
      sinceCmd <= '0;
      needGap  <= '0;
    end else if (!csN && !(rasN && casN && weN)) begin
      assert_spacing_R10: assert (sinceCmd >= needGap);
      sinceCmd <= (WAIT_W + 1)'(1);
      if (!rasN && casN)      needGap <= (WAIT_W + 1)'(T_RP);
      else if (!casN && weN)  needGap <= (WAIT_W + 1)'(T_RFC);
      else                    needGap <= (WAIT_W + 1)'(T_MRD);
    end else if (sinceCmd != '1) begin
      sinceCmd <= sinceCmd + 1'b1;
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int BA_W     = 3,
  parameter int CKE_WAIT = 50000,
  parameter int POST_CKE = 100,
  parameter int DLL_LOCK = 200,
  parameter int T_MRD    = 2,
  parameter int T_RP     = 4,
  parameter int T_RFC    = 32,
  parameter int NUM_REF  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwrStable,
  input  logic [ADDR_W-1:0] modeCfg,
  input  logic [ADDR_W-1:0] extModeCfg,
  output logic              cke,
  output logic              odt,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  seqStrobe_t strobe;
  logic       waitZero;
  logic       dllDone;

  ddr2_init_ctrl #(.NUM_REF(NUM_REF)) uCtrl (
    .clk(clk), .rst(rst), .pwrStable(pwrStable),
    .waitZero(waitZero), .dllDone(dllDone),
    .strobe(strobe), .initDone(initDone)
  );

  ddr2_init_datapath #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CKE_WAIT(CKE_WAIT), .POST_CKE(POST_CKE),
    .DLL_LOCK(DLL_LOCK), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC)
  ) uPath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .modeCfg(modeCfg), .extModeCfg(extModeCfg),
    .cke(cke), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .ba(ba), .addr(addr), .waitZero(waitZero), .dllDone(dllDone)
  );

  assign odt = 1'b0;

  // R11: done only once the lock window counted in the datapath has expired
  assert_done_after_dll_R11: assert property (@(posedge clk) disable iff (rst)
    initDone |-> dllDone);

  // R11: done is sticky
  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

endmodule

// File: tb/sim_ddr2_init_seq.sv
`timescale 1ns/1ps
module sim_ddr2_init_seq;

  localparam int CKE_W = 300;
  localparam int POST  = 100;
  localparam int DLL   = 200;
  localparam int MRD   = 2;
  localparam int RP    = 4;
  localparam int RFC   = 32;
  localparam int NREF  = 2;
  localparam int NCMD  = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwrStable = 1'b0;
  logic [13:0] modeCfg = '0, extModeCfg = '0;
  logic cke, odt, csN, rasN, casN, weN, initDone;
  logic [2:0]  ba;
  logic [13:0] addr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ddr2_init_seq #(
    .ADDR_W(14), .BA_W(3), .CKE_WAIT(CKE_W), .POST_CKE(POST), .DLL_LOCK(DLL),
    .T_MRD(MRD), .T_RP(RP), .T_RFC(RFC), .NUM_REF(NREF)
  ) u0 (
    .clk(clk), .rst(rst), .pwrStable(pwrStable), .modeCfg(modeCfg),
    .extModeCfg(extModeCfg), .cke(cke), .odt(odt), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .ba(ba), .addr(addr), .initDone(initDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // 0 NOP/deselect, 1 PRECHARGE, 2 REFRESH, 3 LOAD MODE, 9 illegal
  function automatic int cmdType();
    if (csN) return 0;
    case ({rasN, casN, weN})
      3'b111: return 0;
      3'b010: return 1;
      3'b001: return 2;
      3'b000: return 3;
      default: return 9;
    endcase
  endfunction

  function automatic int gapAfter(input int t);
    if (t == 1) return RP;
    if (t == 2) return RFC;
    return MRD;
  endfunction

  task automatic checkReset(input string what);
    check(cke == 1'b0 && csN == 1'b1 && {rasN, casN, weN} == 3'b111 &&
          ba == 3'd0 && addr == 14'd0 && initDone == 1'b0 && odt == 1'b0,
          "R1", what, {cke, csN, rasN, casN, weN, initDone, odt}, 7'b0111100);
  endtask

  // reset, load config, hold pwrStable low for a while
  task automatic testHoldOff(input int cycles, input logic [13:0] mv,
                             input logic [13:0] ev);
    int bad = 0;
    rst = 1'b1;
    pwrStable = 1'b0;
    modeCfg = mv;
    extModeCfg = ev;
    repeat (2) @(negedge clk);
    checkReset("reset state");
    rst = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (cke || cmdType() != 0 || initDone || odt) bad++;
    end
    check(bad == 0, "R13", "activity while supply not stable", bad, 0);
  endtask

  task automatic runSequence(input int abortAfter);
    int recT[16], recB[16], recA[16], recC[16];
    int expT[NCMD] = '{1, 3, 3, 3, 3, 1, 2, 2, 3, 3, 3};
    int expB[NCMD] = '{0, 2, 3, 1, 0, 0, 0, 0, 0, 1, 1};
    string tag[NCMD] = '{"R3", "R5", "R5", "R5", "R6", "R7", "R7", "R7",
                         "R8", "R9", "R9"};
    int expA[NCMD], expC[NCMD];
    int nRec = 0, cyc = 0, lowCnt = 0, ckeRise = -1, done = -1;
    int ckeFell = 0, odtBad = 0, illegal = 0, expDone, bad;
    logic [13:0] emrBase;
    pwrStable = 1'b1;
    while (done < 0 && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      if (odt) odtBad++;
      if (ckeRise < 0) begin
        if (!cke) lowCnt++;
        else ckeRise = cyc;
      end else if (!cke) ckeFell++;
      if (cmdType() == 9) illegal++;
      if (cmdType() != 0) begin
        if (nRec < 16) begin
          recT[nRec] = cmdType();
          recB[nRec] = ba;
          recA[nRec] = addr;
          recC[nRec] = cyc;
        end
        nRec++;
      end
      if (initDone) done = cyc;
      if (abortAfter > 0 && nRec == abortAfter) begin
        rst = 1'b1;
        @(negedge clk);
        checkReset("mid-sequence reset");
        pwrStable = 1'b0;
        return;
      end
    end
    check(lowCnt == CKE_W, "R2", "cke low cycles with supply stable", lowCnt, CKE_W);
    check(ckeFell == 0, "R2", "cke dropped after rising", ckeFell, 0);
    check(odtBad == 0, "R12", "odt high cycles", odtBad, 0);
    check(illegal == 0 && nRec == NCMD, "R4", "command count", nRec, NCMD);
    emrBase = extModeCfg & ~14'h0381;
    expA = '{14'h0400, 0, 0, emrBase, modeCfg | 14'h0100, 14'h0400, 0, 0,
             modeCfg & ~14'h0100, emrBase | 14'h0380, emrBase};
    expC[0] = ckeRise + POST;
    for (int i = 1; i < NCMD; i++) expC[i] = expC[i-1] + gapAfter(expT[i-1]);
    for (int i = 0; i < NCMD && i < nRec; i++) begin
      check(recT[i] == expT[i], tag[i], $sformatf("cmd %0d type", i), recT[i], expT[i]);
      check(recB[i] == expB[i], tag[i], $sformatf("cmd %0d bank", i), recB[i], expB[i]);
      check(recA[i] == expA[i], tag[i], $sformatf("cmd %0d addr", i), recA[i], expA[i]);
      check(recC[i] == expC[i], (i == 0) ? "R3" : "R10",
            $sformatf("cmd %0d cycle", i), recC[i], expC[i]);
    end
    expDone = (expC[4] + DLL > expC[NCMD-1] + MRD) ? expC[4] + DLL : expC[NCMD-1] + MRD;
    check(done == expDone, "R11", "initDone cycle", done, expDone);
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (!initDone || !cke || cmdType() != 0 || odt) bad++;
    end
    check(bad == 0, "R11", "state after done", bad, 0);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    // scenario 1: ordinary configuration
    testHoldOff(20, 14'h0A63, 14'h0044);
    runSequence(0);
    // scenario 2: reset in the middle of the script (R1)
    testHoldOff(5, 14'h0A63, 14'h0044);
    runSequence(6);
    // scenario 3: config with every bit set, DLL-reset bit clear
    testHoldOff(3, 14'h0000, 14'h3FFF);
    runSequence(0);
    // scenario 4: mode config with bit 8 already set must still be cleared in R8
    testHoldOff(8, 14'h3FFF, 14'h0381);
    runSequence(0);
    finishRun();
  end

endmodule